// File: doc/BRIEF.md
# Sponge Multi-Block Message Assembler

This block builds the padded input of a sponge hash as a sequence of 136-byte rate blocks and hands each block to an external permutation core. The message is a 32-byte secret, captured from a parallel input when a run starts, followed by a ciphertext of variable length. The ciphertext is fetched one byte at a time from a synchronous memory whose read data appears one cycle after the address.

A select input picks the domain-separation suffix: the extendable-output variant (0x1F) or the fixed-length hash variant (0x06). The block appends the suffix, fills the rest with zeros, and sets the top bit of the final byte. It raises a last-block flag on the final block and pulses done once that block has been taken.

Every block is presented as one 1088-bit word and stays stable until the core accepts it. The permutation itself is outside this block.

Top module: `sponge_block_assembler`

## Requirements
- R1: After reset, `blk_valid_o`, `blk_last_o`, `busy_o` and `done_o` are low.
- R2: Message byte g (0-based) is taken from `prefix_i[8g+7:8g]` for g < 32, and from ciphertext memory address g-32 for 32 <= g < 32+L, where L is `ct_len_i` sampled at start. Within a block, byte k sits at `blk_data_o[8k+7:8k]`, and block b carries message bytes 136b to 136b+135.
- R3: `mem_addr_o` is driven combinationally from the current byte index. It reads g-32 while ciphertext byte g is being fetched, and the byte the memory returns one cycle later is placed correctly, including the first ciphertext byte after the prefix.
- R4: With `suffix_sel_i`=0, byte 32+L is 0x1F, every later byte is 0x00, and the final byte of the final block is ORed with 0x80.
- R5: With `suffix_sel_i`=1, the suffix byte is 0x06 instead of 0x1F. All other padding is the same as in R4.
- R6: When the suffix falls on the final byte of a block, that byte becomes 0x9F (`suffix_sel_i`=0) or 0x86 (`suffix_sel_i`=1), and that block is the final one.
- R7: The number of blocks presented is floor((32+L)/136)+1. For L = 768, 1088 and 1568 this gives 6, 9 and 12 blocks.
- R8: `blk_last_o` is high only together with `blk_valid_o`, and only on the final block.
- R9: While `blk_valid_o` is high and `blk_ready_i` is low, `blk_valid_o` stays high and `blk_data_o` does not change.
- R10: `done_o` is high for exactly one cycle, the cycle after the final block is accepted. `busy_o` is low in that cycle.
- R11: A `start_i` pulse while `busy_o` is high is ignored. The run in progress keeps its length and its block count.
- R12: `prefix_i`, `ct_len_i` and `suffix_sel_i` are sampled only when a run starts. Changing them during the run has no effect on the blocks of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a run (ignored while busy) |
| suffix_sel_i | input | 1 | 0: suffix 0x1F, 1: suffix 0x06 |
| ct_len_i | input | LEN_W | Ciphertext length L in bytes |
| prefix_i | input | 8*PREFIX_BYTES | Secret prefix, byte 0 in the low bits |
| mem_addr_o | output | LEN_W | Ciphertext memory read address |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |
| blk_valid_o | output | 1 | A block is presented |
| blk_ready_i | input | 1 | The permutation core accepts the block |
| blk_data_o | output | 8*RATE_BYTES | Block data, byte 0 in the low bits |
| blk_last_o | output | 1 | The presented block is the final one |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse after the final block is accepted |

## Verification
The hardest conditions to reach are the suffix landing exactly on byte 135 of a block, and the boundary where the source switches from the prefix register to memory data that arrives one cycle late. The bench sweeps every ciphertext length from 0 to 200, alternating the suffix mode. This covers lengths 103 and 104, where the suffix moves from the final byte into an extra all-padding block. Directed runs then cover the three full-size lengths, back-pressure on the ready line, a mid-run start with changed inputs, and a probe of the address at the prefix-to-ciphertext boundary.

// File: rtl/sab_pkg.sv
// Shared types and constants for the sponge block assembler.
// Assumes the rate block is at most 256 bytes (8-bit byte positions are enough).
package sab_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_DRAIN,
        ST_PRESENT
    } sab_state_t;

    typedef enum logic [1:0] {
        SRC_PREFIX,
        SRC_MEM,
        SRC_PAD
    } sab_src_t;

    localparam logic [7:0] SAB_SFX_XOF  = 8'h1F;
    localparam logic [7:0] SAB_SFX_HASH = 8'h06;
    localparam logic [7:0] SAB_PAD_END  = 8'h80;
endpackage

// File: rtl/sab_seq.sv
// Sequencer: walks the global byte index, classifies each byte's source,
// drives the memory read address combinationally and runs the block handshake.
// Assumes the memory returns data exactly one cycle after the address.
module sab_seq
    import sab_pkg::*;
#(
    parameter int RATE_BYTES   = 136,
    parameter int PREFIX_BYTES = 32,
    parameter int LEN_W        = 11,
    localparam int G_W    = LEN_W + 2,
    localparam int POS_W  = $clog2(RATE_BYTES),
    localparam int PIDX_W = $clog2(PREFIX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  ct_len_i,
    input  logic              blk_ready_i,
    output logic              cap_en_o,
    output logic              req_vld_o,
    output logic [POS_W-1:0]  req_pos_o,
    output sab_src_t          req_src_o,
    output logic [PIDX_W-1:0] req_pidx_o,
    output logic              req_first_pad_o,
    output logic              req_final_o,
    output logic [LEN_W-1:0]  mem_addr_o,
    output logic              blk_valid_o,
    output logic              blk_last_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [G_W-1:0]   PFX_G     = G_W'(PREFIX_BYTES);
    localparam logic [G_W-1:0]   RATE_M1_G = G_W'(RATE_BYTES - 1);
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(RATE_BYTES - 1);

    sab_state_t       state_q;
    logic [G_W-1:0]   g_q;
    logic [POS_W-1:0] pos_q;
    logic [G_W-1:0]   total_q;
    logic             last_blk_q;
    logic [G_W-1:0]   total_nxt;

    assign total_nxt = PFX_G + G_W'(ct_len_i);
    assign cap_en_o  = (state_q == ST_IDLE) && start_i;

    // Control state, byte index, block position, total length and last-block flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            g_q        <= '0;
            pos_q      <= '0;
            total_q    <= '0;
            last_blk_q <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        total_q    <= total_nxt;
                        g_q        <= '0;
                        pos_q      <= '0;
                        last_blk_q <= (RATE_M1_G >= total_nxt);
                        state_q    <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    g_q <= g_q + 1'b1;
                    if (pos_q == POS_LAST) begin
                        pos_q   <= '0;
                        state_q <= ST_DRAIN;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
                ST_DRAIN: state_q <= ST_PRESENT;
                ST_PRESENT: begin
                    if (blk_ready_i) begin
                        if (last_blk_q) begin
                            state_q <= ST_IDLE;
                            done_o  <= 1'b1;
                        end else begin
                            last_blk_q <= (g_q + RATE_M1_G >= total_q);
                            state_q    <= ST_FILL;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Source classification of the byte being issued this cycle.
    always_comb begin
        if (g_q < PFX_G)        req_src_o = SRC_PREFIX;
        else if (g_q < total_q) req_src_o = SRC_MEM;
        else                    req_src_o = SRC_PAD;
    end

    assign req_vld_o       = (state_q == ST_FILL);
    assign req_pos_o       = pos_q;
    assign req_pidx_o      = g_q[PIDX_W-1:0];
    assign req_first_pad_o = (g_q == total_q);
    assign req_final_o     = last_blk_q && (pos_q == POS_LAST);
    // Unregistered address, so that the read data lands in the next cycle.
    assign mem_addr_o      = (req_src_o == SRC_MEM) ? LEN_W'(g_q - PFX_G) : '0;

    assign blk_valid_o = (state_q == ST_PRESENT);
    assign blk_last_o  = (state_q == ST_PRESENT) && last_blk_q;
    assign busy_o      = (state_q != ST_IDLE);
endmodule

// File: rtl/sab_byte_mux.sv
// Byte composer: holds the sampled prefix and suffix, delays each request by
// one cycle to meet the memory read data, and forms the byte to store.
// Assumes mem_rdata_i belongs to the address issued in the previous cycle.
module sab_byte_mux
    import sab_pkg::*;
#(
    parameter int RATE_BYTES   = 136,
    parameter int PREFIX_BYTES = 32,
    localparam int POS_W  = $clog2(RATE_BYTES),
    localparam int PIDX_W = $clog2(PREFIX_BYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_en_i,
    input  logic [8*PREFIX_BYTES-1:0] prefix_i,
    input  logic                      suffix_sel_i,
    input  logic                      req_vld_i,
    input  logic [POS_W-1:0]          req_pos_i,
    input  sab_src_t                  req_src_i,
    input  logic [PIDX_W-1:0]         req_pidx_i,
    input  logic                      req_first_pad_i,
    input  logic                      req_final_i,
    input  logic [7:0]                mem_rdata_i,
    output logic                      wr_en_o,
    output logic [POS_W-1:0]          wr_pos_o,
    output logic [7:0]                wr_byte_o
);
    logic [8*PREFIX_BYTES-1:0] prefix_q;
    logic [7:0]                suffix_q;
    logic                      vld_d;
    logic [POS_W-1:0]          pos_d;
    sab_src_t                  src_d;
    logic [PIDX_W-1:0]         pidx_d;
    logic                      first_d;
    logic                      final_d;
    logic [7:0]                base_byte;

    // Capture the prefix and the suffix byte at run start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prefix_q <= '0;
            suffix_q <= SAB_SFX_XOF;
        end else if (cap_en_i) begin
            prefix_q <= prefix_i;
            suffix_q <= suffix_sel_i ? SAB_SFX_HASH : SAB_SFX_XOF;
        end
    end

    // Delay the request by one cycle to line it up with the memory data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_d   <= 1'b0;
            pos_d   <= '0;
            src_d   <= SRC_PAD;
            pidx_d  <= '0;
            first_d <= 1'b0;
            final_d <= 1'b0;
        end else begin
            vld_d   <= req_vld_i;
            pos_d   <= req_pos_i;
            src_d   <= req_src_i;
            pidx_d  <= req_pidx_i;
            first_d <= req_first_pad_i;
            final_d <= req_final_i;
        end
    end

    // Select the byte source and apply the closing pad bit.
    always_comb begin
        unique case (src_d)
            SRC_PREFIX: base_byte = prefix_q[{pidx_d, 3'b000} +: 8];
            SRC_MEM:    base_byte = mem_rdata_i;
            default:    base_byte = first_d ? suffix_q : 8'h00;
        endcase
        wr_byte_o = base_byte | (final_d ? SAB_PAD_END : 8'h00);
    end

    assign wr_en_o  = vld_d;
    assign wr_pos_o = pos_d;
endmodule

// File: rtl/sab_block_buf.sv
// Block buffer: one register per byte lane, written by position and
// read out as a single wide word. Assumes no writes while a block is presented.
module sab_block_buf #(
    parameter int RATE_BYTES = 136,
    localparam int POS_W = $clog2(RATE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [POS_W-1:0]        wr_pos_i,
    input  logic [7:0]              wr_byte_i,
    output logic [8*RATE_BYTES-1:0] data_o
);
    for (genvar i = 0; i < RATE_BYTES; i++) begin : g_lane
        logic [7:0] lane_q;
        // Write this lane when the position matches.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (wr_en_i && (wr_pos_i == POS_W'(i)))
                lane_q <= wr_byte_i;
        end
        assign data_o[8*i +: 8] = lane_q;
    end
endmodule

// File: rtl/sponge_block_assembler.sv
// Top: builds padded sponge rate blocks from a register-held prefix followed
// by bytes from a synchronous memory, and presents them over valid/ready.
// Assumes a one-cycle registered memory read and PREFIX_BYTES <= RATE_BYTES.
module sponge_block_assembler
    import sab_pkg::*;
#(
    parameter int RATE_BYTES   = 136,
    parameter int PREFIX_BYTES = 32,
    parameter int LEN_W        = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      suffix_sel_i,
    input  logic [LEN_W-1:0]          ct_len_i,
    input  logic [8*PREFIX_BYTES-1:0] prefix_i,
    output logic [LEN_W-1:0]          mem_addr_o,
    input  logic [7:0]                mem_rdata_i,
    output logic                      blk_valid_o,
    input  logic                      blk_ready_i,
    output logic [8*RATE_BYTES-1:0]   blk_data_o,
    output logic                      blk_last_o,
    output logic                      busy_o,
    output logic                      done_o
);
    localparam int POS_W  = $clog2(RATE_BYTES);
    localparam int PIDX_W = $clog2(PREFIX_BYTES);

    logic              cap_en;
    logic              req_vld;
    logic [POS_W-1:0]  req_pos;
    sab_src_t          req_src;
    logic [PIDX_W-1:0] req_pidx;
    logic              req_first_pad;
    logic              req_final;
    logic              wr_en;
    logic [POS_W-1:0]  wr_pos;
    logic [7:0]        wr_byte;

    sab_seq #(
        .RATE_BYTES  (RATE_BYTES),
        .PREFIX_BYTES(PREFIX_BYTES),
        .LEN_W       (LEN_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .ct_len_i       (ct_len_i),
        .blk_ready_i    (blk_ready_i),
        .cap_en_o       (cap_en),
        .req_vld_o      (req_vld),
        .req_pos_o      (req_pos),
        .req_src_o      (req_src),
        .req_pidx_o     (req_pidx),
        .req_first_pad_o(req_first_pad),
        .req_final_o    (req_final),
        .mem_addr_o     (mem_addr_o),
        .blk_valid_o    (blk_valid_o),
        .blk_last_o     (blk_last_o),
        .busy_o         (busy_o),
        .done_o         (done_o)
    );

    sab_byte_mux #(
        .RATE_BYTES  (RATE_BYTES),
        .PREFIX_BYTES(PREFIX_BYTES)
    ) u_mux (
        .clk            (clk),
        .rst_n          (rst_n),
        .cap_en_i       (cap_en),
        .prefix_i       (prefix_i),
        .suffix_sel_i   (suffix_sel_i),
        .req_vld_i      (req_vld),
        .req_pos_i      (req_pos),
        .req_src_i      (req_src),
        .req_pidx_i     (req_pidx),
        .req_first_pad_i(req_first_pad),
        .req_final_i    (req_final),
        .mem_rdata_i    (mem_rdata_i),
        .wr_en_o        (wr_en),
        .wr_pos_o       (wr_pos),
        .wr_byte_o      (wr_byte)
    );

    sab_block_buf #(
        .RATE_BYTES(RATE_BYTES)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_pos_i (wr_pos),
        .wr_byte_i(wr_byte),
        .data_o   (blk_data_o)
    );
endmodule

// File: rtl/sab_checker.sv
// Protocol checker for the assembler's handshake and run control,
// attached to every instance of the top module through bind.
module sab_checker #(
    parameter int RATE_BYTES = 136
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    blk_valid_o,
    input logic                    blk_ready_i,
    input logic [8*RATE_BYTES-1:0] blk_data_o,
    input logic                    blk_last_o,
    input logic                    busy_o,
    input logic                    done_o
);
    logic final_take;
    assign final_take = blk_valid_o && blk_ready_i && blk_last_o;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid_o && !blk_ready_i |=> blk_valid_o && $stable(blk_data_o)); // R9
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        blk_last_o |-> blk_valid_o); // R8
    AST_DONE_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(final_take)); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10
    AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid_o |-> busy_o); // R8
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !final_take |=> busy_o && !done_o); // R11
endmodule

bind sponge_block_assembler sab_checker #(.RATE_BYTES(RATE_BYTES)) u_sab_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .blk_valid_o(blk_valid_o),
    .blk_ready_i(blk_ready_i),
    .blk_data_o (blk_data_o),
    .blk_last_o (blk_last_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/tb_sponge_block_assembler.sv
// Bench: a registered-read memory model, a sweep over short lengths and
// directed runs; expected blocks are computed from the requirements.
module tb_sponge_block_assembler;
    localparam int RATE = 136;
    localparam int PFX  = 32;
    localparam int LW   = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              suffix_sel_i = 1'b0;
    logic [LW-1:0]     ct_len_i = '0;
    logic [8*PFX-1:0]  prefix_i = '0;
    logic [LW-1:0]     mem_addr_o;
    logic [7:0]        mem_rdata_i = '0;
    logic              blk_valid_o;
    logic              blk_ready_i = 1'b0;
    logic [8*RATE-1:0] blk_data_o;
    logic              blk_last_o;
    logic              busy_o;
    logic              done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    sponge_block_assembler #(.RATE_BYTES(RATE), .PREFIX_BYTES(PFX), .LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .suffix_sel_i(suffix_sel_i),
        .ct_len_i(ct_len_i), .prefix_i(prefix_i), .mem_addr_o(mem_addr_o),
        .mem_rdata_i(mem_rdata_i), .blk_valid_o(blk_valid_o), .blk_ready_i(blk_ready_i),
        .blk_data_o(blk_data_o), .blk_last_o(blk_last_o), .busy_o(busy_o), .done_o(done_o)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_fn(input int a);
        return 8'((a * 29) + ((a >> 5) * 3) + 7);
    endfunction

    // Memory model with a one-cycle registered read.
    always @(posedge clk) mem_rdata_i <= mem_fn(int'(mem_addr_o));

    function automatic logic [7:0] exp_byte(input int gi, input int total, input bit sel,
                                            input logic [8*PFX-1:0] pre, input int nblk);
        logic [7:0] b;
        b = 8'h00;
        if (gi < PFX)         b = pre[8*gi +: 8];
        else if (gi < total)  b = mem_fn(gi - PFX);
        else if (gi == total) b = sel ? 8'h06 : 8'h1F;
        if (gi == nblk * RATE - 1) b = b | 8'h80;
        return b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic run_case(input int ct, input bit sel, input int hold, input bit disturb,
                            input bit probe, input string tag);
        logic [8*PFX-1:0] pre;
        int total, nblk, b, bad;
        logic [7:0] eb, ab, eb_bad, ab_bad;
        logic [8*RATE-1:0] snap;
        bit seen_last;
        for (int k = 0; k < PFX; k++) pre[8*k +: 8] = 8'(k * 13 + ct + 1);
        total = PFX + ct;
        nblk  = total / RATE + 1;
        @(negedge clk);
        prefix_i = pre; ct_len_i = LW'(ct); suffix_sel_i = sel; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (probe) begin
            repeat (PFX + 1) @(negedge clk);
            chk(mem_addr_o == LW'(1), "R3", "address one byte past prefix", mem_addr_o, 1);
        end
        if (disturb) begin
            repeat (5) @(negedge clk);
            ct_len_i = LW'(5); suffix_sel_i = ~sel; prefix_i = ~pre; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(busy_o && !blk_valid_o, "R11", "still filling after start while busy",
                {busy_o, blk_valid_o}, 2);
        end
        b = 0;
        seen_last = 1'b0;
        while (!seen_last && b < nblk + 2) begin
            while (!blk_valid_o) @(negedge clk);
            bad = -1; eb_bad = 0; ab_bad = 0;
            for (int k = 0; k < RATE; k++) begin
                eb = exp_byte(b * RATE + k, total, sel, pre, nblk);
                ab = blk_data_o[8*k +: 8];
                if (bad < 0 && ab != eb) begin bad = k; eb_bad = eb; ab_bad = ab; end
            end
            chk(bad < 0, tag, $sformatf("block %0d byte %0d (L=%0d)", b, bad, ct), ab_bad, eb_bad);
            chk(blk_last_o == (b == nblk - 1), "R8", $sformatf("last flag block %0d", b),
                blk_last_o, (b == nblk - 1));
            seen_last = blk_last_o;
            if (hold > 0) begin
                snap = blk_data_o;
                repeat (hold) @(negedge clk);
                chk(blk_valid_o && (blk_data_o == snap), "R9", "hold under back-pressure",
                    blk_valid_o, 1);
            end
            blk_ready_i = 1'b1;
            @(negedge clk);
            blk_ready_i = 1'b0;
            b++;
        end
        chk(b == nblk, "R7", $sformatf("block count L=%0d", ct), b, nblk);
        if (disturb) chk(b == nblk, "R11", "block count unchanged by ignored start", b, nblk);
        chk(done_o && !busy_o, "R10", "done after final accept", {done_o, busy_o}, 2);
        @(negedge clk);
        chk(!done_o, "R10", "done single cycle", done_o, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!blk_valid_o && !blk_last_o && !busy_o && !done_o, "R1", "outputs in reset",
            {blk_valid_o, blk_last_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!blk_valid_o && !blk_last_o && !busy_o && !done_o, "R1", "outputs after reset",
            {blk_valid_o, blk_last_o, busy_o, done_o}, 0);

        run_case(768, 1'b0, 0, 1'b0, 1'b0, "R7");
        run_case(1088, 1'b0, 0, 1'b0, 1'b0, "R7");
        run_case(1568, 1'b0, 2, 1'b0, 1'b0, "R7");
        run_case(1088, 1'b1, 0, 1'b0, 1'b0, "R5");
        run_case(0, 1'b0, 0, 1'b0, 1'b0, "R4");
        run_case(103, 1'b0, 0, 1'b0, 1'b0, "R6");
        run_case(103, 1'b1, 0, 1'b0, 1'b0, "R6");
        run_case(104, 1'b0, 1, 1'b0, 1'b0, "R4");
        run_case(40, 1'b0, 0, 1'b0, 1'b1, "R3");
        run_case(300, 1'b1, 0, 1'b1, 1'b0, "R12");
        for (int len = 0; len <= 200; len++)
            run_case(len, (len % 2) == 1, (len % 5 == 0) ? 1 : 0, 1'b0, 1'b0, "R2");
        summary();
    end
endmodule